// File: doc/BRIEF.md
# Smart Card Interrupt Status Register

This block gathers the interrupt causes of a smart card reader interface into one 8-bit status register and raises a single interrupt line towards the processor. The interface logic around it supplies single-cycle event strobes or levels. These cover wait timeout, card insertion or removal or fault, supply timer expiry, receive data present, transmit FIFO flag changes, completed transmission of a byte, and transmit and receive errors. Firmware reads the status over a simple register bus. It gates each cause through a writable enable register.

The bits do not all clear in the same way. Four bits clear when the status register itself is read. Two bits clear only when the transmit control address is read. One bit clears only when the receive control address is read. The receive data bit follows the live receive FIFO level. The card event bit is captured by an asynchronous set flop, so insertions and faults are kept while the main clock is stopped. The flop is then synchronised into the clock domain. A set event always wins over a clear in the same cycle.

Top module: `scard_irq_status`

## Requirements
- R1: After reset the status register (address 0xFE01) reads 0x00, the enable register (address 0xFE02) reads 0x00 and `irq_o` is low.
- R2: A pulse on `wait_tmo_i` sets status bit 7 and a pulse on `supply_tmr_i` sets bit 5. A status read returns the value held before the read and clears both bits.
- R3: A pulse on `tx_done_i` sets status bit 2, which clears on a status read. The bit is not set when `blk_proto_i` is low and `brk_chk_en_i` and `tx_brk_i` are both high in that same cycle.
- R4: Status bit 4 equals `rx_nonempty_i` as sampled at the previous clock edge. A status read does not clear it.
- R5: A rising edge of `tx_empty_i` or of `tx_full_i` sets status bit 3. A read of the transmit control address 0xFE03 clears it, and a status read does not. A flag that stays high does not set it again.
- R6: A pulse on `tx_brk_i` or `tx_undr_i` sets status bit 1. A read of 0xFE03 clears it, and a status read does not.
- R7: A pulse on `rx_ovr_i` or `rx_par_i` sets status bit 0. A read of the receive control address 0xFE04 clears it. Status reads and 0xFE03 reads do not clear it.
- R8: A pulse on `card_chg_i` sets status bit 6 even when it arrives while `clk` is stopped. The bit is visible at most three clock edges after the clock runs again, and a status read clears it.
- R9: `irq_o` is high exactly when some status bit and the enable bit at the same position (address 0xFE02) are both 1. A bit whose enable is 0 still latches its status.
- R10: When a set event and a clearing read of its bit fall in the same cycle, the bit is 1 afterwards.
- R11: A write to address 0xFE02 loads the enable register, and reading that address returns it. Reads of any address other than 0xFE01 and 0xFE02 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main logic clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wait_tmo_i | input | 1 | Wait or answer timeout strobe |
| card_chg_i | input | 1 | Card insertion, removal or fault pulse, asynchronous |
| supply_tmr_i | input | 1 | Supply timer expiry strobe |
| rx_nonempty_i | input | 1 | Receive FIFO holds data (level) |
| tx_empty_i | input | 1 | Transmit FIFO empty flag (level) |
| tx_full_i | input | 1 | Transmit FIFO full flag (level) |
| tx_done_i | input | 1 | Byte (or checksum byte) transmitted |
| blk_proto_i | input | 1 | 1 = block protocol, 0 = character protocol |
| brk_chk_en_i | input | 1 | Break detection enabled |
| tx_brk_i | input | 1 | Break detected at end of transmitted byte |
| tx_undr_i | input | 1 | Transmit underrun strobe |
| rx_ovr_i | input | 1 | Receive overrun strobe |
| rx_par_i | input | 1 | Receive parity error strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
On every cycle the assertions check these rules: the set-wins priority for the wait timeout bit, the read clear of that bit, the one-cycle tracking of the receive level, and that the two error and event bits survive reads other than their own clearing read. They also check transmit-sent suppression under break and the enable register write. The bench scenarios are needed for the card event path, because only they can stop the clock, pulse the card input and count edges after restart. They also cover the full sweep of transmit-sent mode combinations and all 256 enable masks against a latched pattern. Edge-not-level behaviour of the FIFO flags is likewise shown only by a scenario.

// File: rtl/scard_irq_pkg.sv
package scard_irq_pkg;

    localparam int STAT_W = 8;

    // bit positions in the status word
    localparam int B_WAIT   = 7;
    localparam int B_CARD   = 6;
    localparam int B_SUPPLY = 5;
    localparam int B_RXDAV  = 4;
    localparam int B_TXEVT  = 3;
    localparam int B_TXSENT = 2;
    localparam int B_TXERR  = 1;
    localparam int B_RXERR  = 0;

    // which bits each kind of read clears
    localparam logic [STAT_W-1:0] CLR_BY_STAT =
        (STAT_W'(1) << B_WAIT) | (STAT_W'(1) << B_CARD) |
        (STAT_W'(1) << B_SUPPLY) | (STAT_W'(1) << B_TXSENT);
    localparam logic [STAT_W-1:0] CLR_BY_TX =
        (STAT_W'(1) << B_TXEVT) | (STAT_W'(1) << B_TXERR);
    localparam logic [STAT_W-1:0] CLR_BY_RX =
        (STAT_W'(1) << B_RXERR);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] en;
        logic              empty_prev;
        logic              full_prev;
    } irq_regs_t;

endpackage

// File: rtl/scard_bus_dec.sv
module scard_bus_dec #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] A_STAT = 16'hFE01,
    parameter logic [ADDR_W-1:0] A_EN   = 16'hFE02,
    parameter logic [ADDR_W-1:0] A_TXC  = 16'hFE03,
    parameter logic [ADDR_W-1:0] A_RXC  = 16'hFE04
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_stat,
    output logic              hit_en,
    output logic              hit_txc,
    output logic              hit_rxc
);
    always_comb begin
        hit_stat = (addr == A_STAT);
        hit_en   = (addr == A_EN);
        hit_txc  = (addr == A_TXC);
        hit_rxc  = (addr == A_RXC);
    end
endmodule

// File: rtl/scard_card_sync.sv
// Asynchronous-set capture of the card change pulse plus a two-flop
// synchroniser. The capture stays set while clk is stopped. Once the
// synchronised copy reaches the main domain, the capture and the chain
// are cleared so that the next pulse is seen as a new event.
module scard_card_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic evt_sync
);
    logic              cap_q;
    logic [STAGES-1:0] chain_q;
    logic              ack;

    assign ack      = chain_q[STAGES-1];
    assign evt_sync = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n or posedge evt_async) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else if (evt_async) begin
            cap_q <= 1'b1;
        end else if (ack) begin
            cap_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (ack) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], cap_q};
        end
    end
endmodule

// File: rtl/scard_irq_events.sv
// Maps the interface strobes onto per-bit set requests.
module scard_irq_events
    import scard_irq_pkg::*;
(
    input  logic              wait_tmo_i,
    input  logic              card_sync_i,
    input  logic              supply_tmr_i,
    input  logic              tx_empty_i,
    input  logic              tx_full_i,
    input  logic              empty_prev_i,
    input  logic              full_prev_i,
    input  logic              tx_done_i,
    input  logic              blk_proto_i,
    input  logic              brk_chk_en_i,
    input  logic              tx_brk_i,
    input  logic              tx_undr_i,
    input  logic              rx_ovr_i,
    input  logic              rx_par_i,
    output logic [STAT_W-1:0] set_o
);
    logic sent_blocked;

    always_comb begin
        sent_blocked      = !blk_proto_i && brk_chk_en_i && tx_brk_i;
        set_o             = '0;
        set_o[B_WAIT]     = wait_tmo_i;
        set_o[B_CARD]     = card_sync_i;
        set_o[B_SUPPLY]   = supply_tmr_i;
        set_o[B_RXDAV]    = 1'b0;
        set_o[B_TXEVT]    = (tx_empty_i && !empty_prev_i) ||
                            (tx_full_i && !full_prev_i);
        set_o[B_TXSENT]   = tx_done_i && !sent_blocked;
        set_o[B_TXERR]    = tx_brk_i || tx_undr_i;
        set_o[B_RXERR]    = rx_ovr_i || rx_par_i;
    end
endmodule

// File: rtl/scard_irq_status.sv
module scard_irq_status
    import scard_irq_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] A_STAT = 16'hFE01,
    parameter logic [ADDR_W-1:0] A_EN   = 16'hFE02,
    parameter logic [ADDR_W-1:0] A_TXC  = 16'hFE03,
    parameter logic [ADDR_W-1:0] A_RXC  = 16'hFE04,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic              wait_tmo_i,
    input  logic              card_chg_i,
    input  logic              supply_tmr_i,
    input  logic              rx_nonempty_i,
    input  logic              tx_empty_i,
    input  logic              tx_full_i,
    input  logic              tx_done_i,
    input  logic              blk_proto_i,
    input  logic              brk_chk_en_i,
    input  logic              tx_brk_i,
    input  logic              tx_undr_i,
    input  logic              rx_ovr_i,
    input  logic              rx_par_i,
    output logic              irq_o
);
    irq_regs_t cur_q, nxt_d;

    logic hit_stat, hit_en, hit_txc, hit_rxc;
    logic card_sync;
    logic [STAT_W-1:0] set_v, clr_v;
    logic [STAT_W-1:0] stat_vec, en_vec;

    scard_bus_dec #(
        .ADDR_W (ADDR_W),
        .A_STAT (A_STAT),
        .A_EN   (A_EN),
        .A_TXC  (A_TXC),
        .A_RXC  (A_RXC)
    ) i_dec (
        .addr     (bus_addr),
        .hit_stat (hit_stat),
        .hit_en   (hit_en),
        .hit_txc  (hit_txc),
        .hit_rxc  (hit_rxc)
    );

    scard_card_sync #(
        .STAGES (SYNC_STAGES)
    ) i_card (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (card_chg_i),
        .evt_sync  (card_sync)
    );

    scard_irq_events i_evt (
        .wait_tmo_i   (wait_tmo_i),
        .card_sync_i  (card_sync),
        .supply_tmr_i (supply_tmr_i),
        .tx_empty_i   (tx_empty_i),
        .tx_full_i    (tx_full_i),
        .empty_prev_i (cur_q.empty_prev),
        .full_prev_i  (cur_q.full_prev),
        .tx_done_i    (tx_done_i),
        .blk_proto_i  (blk_proto_i),
        .brk_chk_en_i (brk_chk_en_i),
        .tx_brk_i     (tx_brk_i),
        .tx_undr_i    (tx_undr_i),
        .rx_ovr_i     (rx_ovr_i),
        .rx_par_i     (rx_par_i),
        .set_o        (set_v)
    );

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.empty_prev = tx_empty_i;
        nxt_d.full_prev  = tx_full_i;

        clr_v = ({STAT_W{bus_rd && hit_stat}} & CLR_BY_STAT) |
                ({STAT_W{bus_rd && hit_txc}}  & CLR_BY_TX)   |
                ({STAT_W{bus_rd && hit_rxc}}  & CLR_BY_RX);

        // set wins over clear
        nxt_d.stat          = set_v | (cur_q.stat & ~clr_v);
        nxt_d.stat[B_RXDAV] = rx_nonempty_i;

        if (bus_wr && hit_en) begin
            nxt_d.en = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat_vec = cur_q.stat;
    assign en_vec   = cur_q.en;

    always_comb begin
        if (hit_stat) begin
            bus_rdata = stat_vec;
        end else if (hit_en) begin
            bus_rdata = en_vec;
        end else begin
            bus_rdata = '0;
        end
    end

    assign irq_o = |(stat_vec & en_vec);

endmodule

// File: rtl/scard_irq_chk.sv
module scard_irq_chk
    import scard_irq_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] A_STAT = 16'hFE01,
    parameter logic [ADDR_W-1:0] A_EN   = 16'hFE02,
    parameter logic [ADDR_W-1:0] A_TXC  = 16'hFE03,
    parameter logic [ADDR_W-1:0] A_RXC  = 16'hFE04
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [STAT_W-1:0] bus_wdata,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] en,
    input logic              wait_tmo_i,
    input logic              rx_nonempty_i,
    input logic              tx_done_i,
    input logic              blk_proto_i,
    input logic              brk_chk_en_i,
    input logic              tx_brk_i
);
    logic rd_stat, rd_txc, rd_rxc, wr_en;
    logic past_rst_n;

    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign rd_txc  = bus_rd && (bus_addr == A_TXC);
    assign rd_rxc  = bus_rd && (bus_addr == A_RXC);
    assign wr_en   = bus_wr && (bus_addr == A_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_rst_n <= 1'b0;
        else        past_rst_n <= 1'b1;
    end

    // R10
    wait_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_tmo_i |=> stat[B_WAIT]);

    // R2
    wait_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !wait_tmo_i) |=> !stat[B_WAIT]);

    // R4
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_rst_n |=> (stat[B_RXDAV] == $past(rx_nonempty_i)));

    // R5
    txevt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_TXEVT] && !rd_txc) |=> stat[B_TXEVT]);

    // R7
    rxerr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_RXERR] && !rd_rxc) |=> stat[B_RXERR]);

    // R3
    sent_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_i && !blk_proto_i && brk_chk_en_i && tx_brk_i && !stat[B_TXSENT])
        |=> !stat[B_TXSENT]);

    // R11
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en == $past(bus_wdata)));

endmodule

bind scard_irq_status scard_irq_chk #(
    .ADDR_W (ADDR_W),
    .A_STAT (A_STAT),
    .A_EN   (A_EN),
    .A_TXC  (A_TXC),
    .A_RXC  (A_RXC)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .stat          (stat_vec),
    .en            (en_vec),
    .wait_tmo_i    (wait_tmo_i),
    .rx_nonempty_i (rx_nonempty_i),
    .tx_done_i     (tx_done_i),
    .blk_proto_i   (blk_proto_i),
    .brk_chk_en_i  (brk_chk_en_i),
    .tx_brk_i      (tx_brk_i)
);

// File: tb/test_scard_irq_status.sv
`timescale 1ns/1ps
module test_scard_irq_status;

    localparam logic [15:0] A_STAT = 16'hFE01;
    localparam logic [15:0] A_EN   = 16'hFE02;
    localparam logic [15:0] A_TXC  = 16'hFE03;
    localparam logic [15:0] A_RXC  = 16'hFE04;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic wait_tmo = 0, card_chg = 0, supply_tmr = 0, rx_ne = 0;
    logic tx_empty = 0, tx_full = 0, tx_done = 0, blk = 0, bdet = 0;
    logic tx_brk = 0, tx_undr = 0, rx_ovr = 0, rx_par = 0;
    logic irq;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #5 if (clk_run) clk = ~clk;

    scard_irq_status i_scard_irq_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .wait_tmo_i    (wait_tmo),
        .card_chg_i    (card_chg),
        .supply_tmr_i  (supply_tmr),
        .rx_nonempty_i (rx_ne),
        .tx_empty_i    (tx_empty),
        .tx_full_i     (tx_full),
        .tx_done_i     (tx_done),
        .blk_proto_i   (blk),
        .brk_chk_en_i  (bdet),
        .tx_brk_i      (tx_brk),
        .tx_undr_i     (tx_undr),
        .rx_ovr_i      (rx_ovr),
        .rx_par_i      (rx_par),
        .irq_o         (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    // 0 wait,1 supply,2 done,3 brk,4 undr,5 ovr,6 par
    task automatic pulse(input int idx);
        @(negedge clk);
        case (idx)
            0: wait_tmo = 1; 1: supply_tmr = 1; 2: tx_done = 1; 3: tx_brk = 1;
            4: tx_undr = 1;  5: rx_ovr = 1;     default: rx_par = 1;
        endcase
        @(negedge clk);
        wait_tmo = 0; supply_tmr = 0; tx_done = 0; tx_brk = 0;
        tx_undr = 0; rx_ovr = 0; rx_par = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_STAT, v); check("R1 status", v, 8'h00);
        rd(A_EN, v);   check("R1 enable", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R11 enable register and unmapped read
        wr(A_EN, 8'h5A); rd(A_EN, v); check("R11 enable rd", v, 8'h5A);
        rd(16'h1234, v); check("R11 unmapped", v, 8'h00);
        wr(A_EN, 8'h00);

        // R2 wait timeout and supply timer
        pulse(0); rd(A_STAT, v); check("R2 wait set", v, 8'h80);
        rd(A_STAT, v); check("R2 wait clr", v, 8'h00);
        pulse(1); rd(A_STAT, v); check("R2 supply set", v, 8'h20);
        rd(A_STAT, v); check("R2 supply clr", v, 8'h00);

        // R3 transmit sent, all mode combinations
        for (int c = 0; c < 8; c++) begin
            logic eb, ed, ek;
            eb = c[0]; ed = c[1]; ek = c[2];
            @(negedge clk);
            blk = eb; bdet = ed; tx_brk = ek; tx_done = 1;
            @(negedge clk);
            tx_done = 0; tx_brk = 0; blk = 0; bdet = 0;
            exp = 8'h00;
            exp[2] = eb | ~ed | ~ek;
            exp[1] = ek;
            rd(A_STAT, v); check("R3 sent combo", v, exp);
            rd(A_STAT, v); check("R3 sent cleared", v, {6'd0, ek, 1'b0});
            rd(A_TXC, v);
            rd(A_STAT, v); check("R3 all clear", v, 8'h00);
        end

        // R4 receive data level
        @(negedge clk); rx_ne = 1; @(negedge clk);
        rd(A_STAT, v); check("R4 rxdav set", v, 8'h10);
        rd(A_STAT, v); check("R4 rxdav kept", v, 8'h10);
        @(negedge clk); rx_ne = 0; @(negedge clk);
        rd(A_STAT, v); check("R4 rxdav clr", v, 8'h00);

        // R5 transmit FIFO flag edges
        @(negedge clk); tx_empty = 1; @(negedge clk);
        rd(A_STAT, v); check("R5 empty edge", v, 8'h08);
        rd(A_STAT, v); check("R5 kept by stat rd", v, 8'h08);
        rd(A_TXC, v);
        rd(A_STAT, v); check("R5 no refire on level", v, 8'h00);
        @(negedge clk); tx_empty = 0; tx_full = 1; @(negedge clk);
        rd(A_STAT, v); check("R5 full edge", v, 8'h08);
        rd(A_TXC, v); @(negedge clk); tx_full = 0;
        rd(A_STAT, v); check("R5 full clr", v, 8'h00);

        // R6 transmit error
        pulse(4); rd(A_STAT, v); check("R6 underrun", v, 8'h02);
        rd(A_RXC, v); rd(A_STAT, v); check("R6 kept", v, 8'h02);
        rd(A_TXC, v); rd(A_STAT, v); check("R6 clr", v, 8'h00);
        pulse(3); rd(A_STAT, v); check("R6 break", v, 8'h02);
        rd(A_TXC, v);

        // R7 receive error
        pulse(5); pulse(6); rd(A_STAT, v); check("R7 set", v, 8'h01);
        rd(A_TXC, v); rd(A_STAT, v); check("R7 kept", v, 8'h01);
        rd(A_RXC, v); rd(A_STAT, v); check("R7 clr", v, 8'h00);

        // R8 card event with stopped clock
        @(negedge clk); clk_run = 0;
        #20 card_chg = 1; #3 card_chg = 0; #20;
        clk_run = 1;
        idle(4);
        rd(A_STAT, v); check("R8 captured while stopped", v, 8'h40);
        rd(A_STAT, v); check("R8 clr", v, 8'h00);
        @(negedge clk); #2 card_chg = 1; #2 card_chg = 0;
        idle(4);
        rd(A_STAT, v); check("R8 running clock", v, 8'h40);

        // R10 set and clearing read in the same cycle
        @(negedge clk);
        bus_addr = A_STAT; bus_rd = 1; wait_tmo = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0; wait_tmo = 0; bus_addr = '0;
        check("R10 read before set", v, 8'h00);
        rd(A_STAT, v); check("R10 set kept", v, 8'h80);
        @(negedge clk);
        bus_addr = A_TXC; bus_rd = 1; tx_undr = 1;
        @(negedge clk);
        bus_rd = 0; tx_undr = 0; bus_addr = '0;
        rd(A_STAT, v); check("R10 txerr kept", v, 8'h02);
        rd(A_TXC, v);

        // R9 enable sweep over a latched pattern 0xA3
        pulse(0); pulse(1); pulse(4); pulse(5);
        rd(A_EN, v);
        for (int m = 0; m < 256; m++) begin
            wr(A_EN, 8'(m));
            check("R9 irq mask", {7'd0, irq}, {7'd0, |(8'hA3 & 8'(m))});
        end
        wr(A_EN, 8'h00);
        rd(A_STAT, v); check("R9 masked still latched", v, 8'hA3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule